// File: doc/BRIEF.md
# Paged Serial Memory Write Controller

This block sits behind the memory personality of a two-wire serial slave. It turns that slave's byte-level events into accesses to a 256 x 8 byte store. The front end decodes the bus. It reports each header byte with its read/write bit, each byte received from the master, each request for a byte to send, and each STOP condition. This block decides whether to acknowledge, keeps the address pointer, and returns read data.

A write transaction carries one word address and then a run of data bytes. The data bytes are gathered in a page buffer. Inside that buffer the pointer advances only in its low bits, so the bytes wrap within one page. A STOP commits the buffered bytes in a single self-timed busy period whose length is a parameter in clock cycles. While that period runs, the block refuses every header, so a host can poll the acknowledge to learn when the write is done. A write-lock input held high at the STOP drops the commit. Reads return the byte under the pointer and step the pointer over the full address range.

Top module: `eep_page_ctrl`

## Requirements
- R1: After reset `busy_o`, `ack_o` and `rbyte_valid_o` are low, the pointer is 0 and every byte of the store reads 0.
- R2: A header pulse (`hdr_valid_i`) that arrives while not busy is acknowledged by `ack_o` high in the following cycle. The bit `hdr_read_i`=1 selects a read session and 0 selects a write session.
- R3: The first byte received in a write session is the word address. It is acknowledged and loads all 8 pointer bits.
- R4: Each later byte in a write session is buffered at the pointer's low 4 bits and acknowledged. Only those low 4 bits then increment, wrapping from 15 to 0, and the upper 4 bits stay unchanged.
- R5: When a write session carries more than 16 data bytes, each byte past the 16th replaces the byte that was buffered earlier at the same page offset.
- R6: A STOP that ends a write session holding at least one data byte, with `wr_lock_i` low, drives `busy_o` high for exactly WR_CYCLES cycles starting the next cycle. When busy falls, the buffered bytes are in the store, and bytes of the page that were not written keep their old values.
- R7: A STOP or a new header that follows a write session with no data byte starts no busy period. A new header also discards any bytes still buffered. Such a session only moves the pointer.
- R8: When `wr_lock_i` is high at the STOP, the data bytes are still acknowledged, but no busy period starts and the store is left unchanged.
- R9: While busy, a header gets `ack_o` low. The bytes and read requests that follow it produce neither an acknowledge nor read data.
- R10: In a read session, a request (`rbyte_req_i`) yields `rbyte_valid_o` high in the next cycle, with the byte at the pointer. The pointer then increments over all 8 bits, wrapping from 255 to 0.
- R11: After a write the pointer rests one past the last byte written, within the page. A later read session with no word address continues from that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_lock_i | input | 1 | High blocks the commit of buffered data |
| hdr_valid_i | input | 1 | Pulse: memory header byte received (START or repeated START) |
| hdr_read_i | input | 1 | Read/write bit of the header, 1 = read |
| wbyte_valid_i | input | 1 | Pulse: byte received from the master |
| wbyte_i | input | 8 | Received byte |
| rbyte_req_i | input | 1 | Pulse: master requests a byte |
| stop_i | input | 1 | Pulse: STOP condition |
| ack_o | output | 1 | Acknowledge for the header or byte of the previous cycle |
| rbyte_valid_o | output | 1 | Read byte valid |
| rbyte_o | output | 8 | Read byte |
| busy_o | output | 1 | Self-timed write cycle in progress |

## Verification
Each response comes from a register and is due one cycle after the input pulse that causes it. This covers the acknowledge, the read byte with its valid flag, and the rise of busy after a STOP. The bench drives each pulse for one full cycle starting at a falling edge. It samples the outputs at the next falling edge, which lies half a period after the edge that updates them. The busy period is measured by counting the falling edges at which busy is high, starting with the one right after the STOP, and the count is compared with WR_CYCLES. The store is checked after busy falls, always through reads at the ports, against a model of the store kept in the bench.

// File: rtl/eep_pkg.sv
package eep_pkg;
   typedef enum logic [1:0] {
      SES_IDLE  = 2'd0,
      SES_WADDR = 2'd1,
      SES_WDATA = 2'd2,
      SES_READ  = 2'd3
   } ses_e;
endpackage

// File: rtl/eep_busy_timer.sv
module eep_busy_timer #(
   parameter int unsigned WR_CYCLES = 1250000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic busy_o,
   output logic fire_o
);
   localparam int unsigned CNT_W = $clog2(WR_CYCLES + 1);

   generate
      if (WR_CYCLES < 1) begin : g_bad_cycles
         $error("WR_CYCLES must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic             busy_q;

   assign fire_o = busy_q && (cnt_q == CNT_W'(1));
   assign busy_o = busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         busy_q <= 1'b0;
      end else if (start_i) begin
         cnt_q  <= CNT_W'(WR_CYCLES);
         busy_q <= 1'b1;
      end else if (busy_q) begin
         if (cnt_q == CNT_W'(1)) busy_q <= 1'b0;
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |-> !busy_q); // R6
   AST_BUSY_UNTIL_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !fire_o) |=> busy_q); // R6
endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned PAGE_W = 4,
   parameter int unsigned HI_W   = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         clr_i,
   input  logic                         load_i,
   input  logic [HI_W-1:0]              page_i,
   input  logic [PAGE_W-1:0]            off_i,
   input  logic [DATA_W-1:0]            data_i,
   output logic [HI_W-1:0]              page_o,
   output logic [(1<<PAGE_W)-1:0]       mask_o,
   output logic [(1<<PAGE_W)*DATA_W-1:0] data_o,
   output logic                         any_o
);
   localparam int unsigned DEPTH = 1 << PAGE_W;

   logic [DATA_W-1:0] slot_q [DEPTH];
   logic [DEPTH-1:0]  mask_q;
   logic [HI_W-1:0]   page_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         page_q <= '0;
      end else if (clr_i) begin
         mask_q <= '0;
      end else if (load_i) begin
         mask_q[off_i] <= 1'b1;
         page_q        <= page_i;
      end
   end

   generate
      for (genvar j = 0; j < DEPTH; j++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) slot_q[j] <= '0;
            else if (load_i && !clr_i && (off_i == PAGE_W'(j))) slot_q[j] <= data_i;
         end
         assign data_o[j*DATA_W +: DATA_W] = slot_q[j];
      end
   endgenerate

   assign mask_o = mask_q;
   assign page_o = page_q;
   assign any_o  = |mask_q;

   AST_LOAD_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && !clr_i) |=> any_o); // R4
endmodule

// File: rtl/eep_store.sv
module eep_store #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned PAGE_W = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          commit_i,
   input  logic [ADDR_W-PAGE_W-1:0]      page_i,
   input  logic [(1<<PAGE_W)-1:0]        mask_i,
   input  logic [(1<<PAGE_W)*DATA_W-1:0] data_i,
   input  logic [ADDR_W-1:0]             raddr_i,
   output logic [DATA_W-1:0]             rdata_o
);
   localparam int unsigned WORDS = 1 << ADDR_W;
   localparam int unsigned DEPTH = 1 << PAGE_W;
   localparam int unsigned HI_W  = ADDR_W - PAGE_W;

   logic [DATA_W-1:0] mem_q [WORDS];

   generate
      for (genvar w = 0; w < WORDS; w++) begin : g_word
         localparam int unsigned OFF = w % DEPTH;
         localparam int unsigned PG  = w / DEPTH;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) mem_q[w] <= '0;
            else if (commit_i && mask_i[OFF] && (page_i == HI_W'(PG)))
               mem_q[w] <= data_i[OFF*DATA_W +: DATA_W];
         end
      end
   endgenerate

   assign rdata_o = mem_q[raddr_i];

   AST_COMMIT_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      commit_i |-> (mask_i != '0)); // R6
endmodule

// File: rtl/eep_page_ctrl.sv
module eep_page_ctrl #(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned PAGE_W    = 4,
   parameter int unsigned WR_CYCLES = 1250000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_lock_i,
   input  logic              hdr_valid_i,
   input  logic              hdr_read_i,
   input  logic              wbyte_valid_i,
   input  logic [DATA_W-1:0] wbyte_i,
   input  logic              rbyte_req_i,
   input  logic              stop_i,
   output logic              ack_o,
   output logic              rbyte_valid_o,
   output logic [DATA_W-1:0] rbyte_o,
   output logic              busy_o
);
   import eep_pkg::*;

   localparam int unsigned HI_W  = ADDR_W - PAGE_W;
   localparam int unsigned DEPTH = 1 << PAGE_W;

   generate
      if (PAGE_W < 1 || PAGE_W >= ADDR_W) begin : g_bad_page
         $error("PAGE_W must lie between 1 and ADDR_W-1");
      end
      if (DATA_W < ADDR_W) begin : g_bad_data
         $error("DATA_W must hold a full word address");
      end
   endgenerate

   ses_e                     ses_q;
   logic [ADDR_W-1:0]        ptr_q;
   logic                     ack_q, rv_q;
   logic [DATA_W-1:0]        rd_q;
   logic                     busy, fire, start;
   logic                     buf_clr, buf_load, buf_any;
   logic [HI_W-1:0]          buf_page;
   logic [DEPTH-1:0]         buf_mask;
   logic [DEPTH*DATA_W-1:0]  buf_data;
   logic [DATA_W-1:0]        mem_rd;

   assign buf_clr  = hdr_valid_i && !busy;
   assign buf_load = wbyte_valid_i && (ses_q == SES_WDATA);
   assign start    = stop_i && (ses_q == SES_WDATA) && buf_any && !wr_lock_i && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ses_q <= SES_IDLE;
         ptr_q <= '0;
         ack_q <= 1'b0;
         rv_q  <= 1'b0;
         rd_q  <= '0;
      end else begin
         ack_q <= 1'b0;
         rv_q  <= 1'b0;
         if (hdr_valid_i) begin
            if (!busy) begin
               ack_q <= 1'b1;
               ses_q <= hdr_read_i ? SES_READ : SES_WADDR;
            end else begin
               ses_q <= SES_IDLE;
            end
         end else if (stop_i) begin
            ses_q <= SES_IDLE;
         end else if (wbyte_valid_i) begin
            case (ses_q)
               SES_WADDR: begin
                  ptr_q <= wbyte_i[ADDR_W-1:0];
                  ack_q <= 1'b1;
                  ses_q <= SES_WDATA;
               end
               SES_WDATA: begin
                  ptr_q[PAGE_W-1:0] <= ptr_q[PAGE_W-1:0] + PAGE_W'(1);
                  ack_q <= 1'b1;
               end
               default: ;
            endcase
         end else if (rbyte_req_i && ses_q == SES_READ) begin
            rd_q  <= mem_rd;
            rv_q  <= 1'b1;
            ptr_q <= ptr_q + ADDR_W'(1);
         end
      end
   end

   eep_busy_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n), .start_i(start), .busy_o(busy), .fire_o(fire)
   );

   eep_page_buf #(.DATA_W(DATA_W), .PAGE_W(PAGE_W), .HI_W(HI_W)) u_buf (
      .clk(clk), .rst_n(rst_n), .clr_i(buf_clr), .load_i(buf_load),
      .page_i(ptr_q[ADDR_W-1:PAGE_W]), .off_i(ptr_q[PAGE_W-1:0]), .data_i(wbyte_i),
      .page_o(buf_page), .mask_o(buf_mask), .data_o(buf_data), .any_o(buf_any)
   );

   eep_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_store (
      .clk(clk), .rst_n(rst_n), .commit_i(fire), .page_i(buf_page),
      .mask_i(buf_mask), .data_i(buf_data), .raddr_i(ptr_q), .rdata_o(mem_rd)
   );

   assign ack_o         = ack_q;
   assign rbyte_valid_o = rv_q;
   assign rbyte_o       = rd_q;
   assign busy_o        = busy;

   AST_HDR_NACK_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (hdr_valid_i && busy) |=> !ack_o); // R9
   AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (wbyte_valid_i && !hdr_valid_i && !stop_i && ses_q == SES_WDATA)
      |=> (ptr_q[ADDR_W-1:PAGE_W] == $past(ptr_q[ADDR_W-1:PAGE_W]))); // R4
   AST_RD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      rbyte_valid_o |-> (ptr_q == $past(ptr_q) + ADDR_W'(1))); // R10
   AST_LOCK_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_i && wr_lock_i && !busy) |=> !busy_o); // R8
   AST_BUSY_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && ses_q != SES_READ && rbyte_req_i) |=> !rbyte_valid_o); // R9
endmodule

// File: tb/eep_page_ctrl_tb.sv
module eep_page_ctrl_tb;
   localparam int W = 40;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_lock = 1'b0, hdr_v = 1'b0, hdr_rd = 1'b0, wb_v = 1'b0, rreq = 1'b0, stp = 1'b0;
   logic [7:0] wb = 8'h00;
   logic ack, rvalid, busy;
   logic [7:0] rbyte;

   int checks = 0;
   int errors = 0;
   logic [7:0] model [256];

   always #2 clk = ~clk;

   eep_page_ctrl #(.WR_CYCLES(W)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_lock_i(wr_lock), .hdr_valid_i(hdr_v),
      .hdr_read_i(hdr_rd), .wbyte_valid_i(wb_v), .wbyte_i(wb), .rbyte_req_i(rreq),
      .stop_i(stp), .ack_o(ack), .rbyte_valid_o(rvalid), .rbyte_o(rbyte), .busy_o(busy)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic send_hdr(input logic rd, output logic a);
      @(negedge clk); hdr_v = 1'b1; hdr_rd = rd;
      @(negedge clk); hdr_v = 1'b0; a = ack;
   endtask

   task automatic send_byte(input logic [7:0] b, output logic a);
      @(negedge clk); wb_v = 1'b1; wb = b;
      @(negedge clk); wb_v = 1'b0; a = ack;
   endtask

   task automatic get_byte(output logic v, output logic [7:0] d);
      @(negedge clk); rreq = 1'b1;
      @(negedge clk); rreq = 1'b0; v = rvalid; d = rbyte;
   endtask

   task automatic send_stop();
      @(negedge clk); stp = 1'b1;
      @(negedge clk); stp = 1'b0;
   endtask

   task automatic wait_idle(output int n);
      n = 0;
      while (busy && n < 100000) begin n++; @(negedge clk); end
   endtask

   task automatic write_page(input logic [7:0] addr, input int cnt, input logic [7:0] base,
                             input string req);
      logic a;
      logic [7:0] p = addr;
      send_hdr(1'b0, a); chk({req, " header ack"}, a, 1);
      send_byte(addr, a); chk("R3 address ack", a, 1);
      for (int i = 0; i < cnt; i++) begin
         send_byte(base + 8'(i), a);
         chk({req, " data ack"}, a, 1);
         if (!wr_lock) model[p] = base + 8'(i);
         p = {p[7:4], p[3:0] + 4'd1};
      end
      send_stop();
   endtask

   task automatic read_at(input logic [7:0] addr, input int cnt, input string req);
      logic a, v;
      logic [7:0] d;
      logic [7:0] p = addr;
      send_hdr(1'b0, a);
      send_byte(addr, a);
      send_hdr(1'b1, a); chk("R2 read header ack", a, 1);
      for (int i = 0; i < cnt; i++) begin
         get_byte(v, d);
         chk({req, " valid"}, v, 1);
         chk({req, " data"}, d, model[p]);
         p = p + 8'd1;
      end
      send_stop();
      chk("R7 no busy after read", busy, 0);
   endtask

   task automatic t_reset();
      logic a, v;
      logic [7:0] d;
      chk("R1 busy", busy, 0);
      chk("R1 ack", ack, 0);
      chk("R1 rvalid", rvalid, 0);
      send_hdr(1'b1, a); chk("R2 ack", a, 1);
      get_byte(v, d); chk("R1 ptr0 valid", v, 1); chk("R1 data zero", d, 0);
      send_stop();
   endtask

   task automatic t_basic();
      int n;
      write_page(8'h10, 3, 8'hAA, "R4");
      chk("R6 busy rises", busy, 1);
      wait_idle(n); chk("R6 busy length", n, W);
      read_at(8'h10, 4, "R6");
   endtask

   task automatic t_wrap();
      int n;
      logic a, v;
      logic [7:0] d;
      write_page(8'h1E, 4, 8'h01, "R4");
      wait_idle(n);
      send_hdr(1'b1, a);
      get_byte(v, d); chk("R11 continue valid", v, 1); chk("R11 continue data", d, model[8'h12]);
      send_stop();
      read_at(8'h1E, 2, "R4");
      read_at(8'h10, 3, "R4");
   endtask

   task automatic t_over();
      int n;
      write_page(8'h40, 18, 8'h50, "R5");
      wait_idle(n);
      chk("R5 slot0", model[8'h40], 8'h60);
      read_at(8'h40, 16, "R5");
   endtask

   task automatic t_busy_nack();
      int n;
      logic a, v;
      logic [7:0] d;
      write_page(8'h60, 1, 8'h77, "R6");
      send_hdr(1'b0, a); chk("R9 write header nack", a, 0);
      send_byte(8'h33, a); chk("R9 byte nack", a, 0);
      send_hdr(1'b1, a); chk("R9 read header nack", a, 0);
      get_byte(v, d); chk("R9 no read data", v, 0);
      send_stop();
      wait_idle(n);
      read_at(8'h60, 2, "R9");
   endtask

   task automatic t_addr_only();
      logic a, v;
      logic [7:0] d;
      send_hdr(1'b0, a);
      send_byte(8'h12, a); chk("R3 ack", a, 1);
      send_stop();
      chk("R7 no busy", busy, 0);
      send_hdr(1'b1, a);
      get_byte(v, d); chk("R7 pointer loaded", d, model[8'h12]);
      send_stop();
      read_at(8'h30, 1, "R7");
   endtask

   task automatic t_lock();
      wr_lock = 1'b1;
      write_page(8'h80, 2, 8'h11, "R8");
      chk("R8 no busy", busy, 0);
      wr_lock = 1'b0;
      read_at(8'h80, 2, "R8");
   endtask

   task automatic t_rd_wrap();
      int n;
      write_page(8'hFF, 1, 8'hA5, "R10");
      wait_idle(n);
      read_at(8'hFF, 2, "R10");
   endtask

   initial begin
      for (int i = 0; i < 256; i++) model[i] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_wrap();
      t_over();
      t_busy_nack();
      t_addr_only();
      t_lock();
      t_rd_wrap();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #400000;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule